// File: doc/BRIEF.md
# Byte Lane Select Generator

This block drives the four byte-lane select pins of an external static memory port. For each accepted access it takes the transfer size, the two low address bits, the direction, the byte order and a bank index. The bank index picks a data width and a read-lane-enable bit out of a set of per-bank configuration vectors. From these inputs it works out which external byte lanes carry the addressed bytes.

On writes it asserts only those lanes. On reads it drives all lanes to one level, chosen per bank: all asserted for banks of 16- or 32-bit devices, or all deasserted for banks whose lane pins are wired as byte write enables. Transfers larger than a word are refused with an error pulse and no lane activity. The active level of the lane pins comes from a strap that is sampled while reset is held.

The result is registered and appears one clock after the request cycle. With no request, the lanes rest at their deasserted level.

Top module: `lane_select_gen`

## Requirements
- R1: While reset is held and on every later cycle with no lane asserted, each `lane_sel` bit equals the inverse of the strap value seen during reset. With the strap at 0 the idle and reset level is 4'b1111 (active low). With the strap at 1 it is 4'b0000 (active high).
- R2: `pol_strap` is sampled only while `rst_n` is low. Changing it after reset has no effect on `lane_sel` until the next reset.
- R3: A request with `size` code 3 to 7 pulses `err` high in the following cycle and asserts no lane. Size codes are 0 = byte, 1 = halfword, 2 = word.
- R4: A read (`wr` = 0) with a legal size asserts all four lanes when the selected bank's `cfg_rden` bit is 1, and asserts none when it is 0. Size, address and byte order do not change the result.
- R5: A write to a bank of width code 0 (8 bits) asserts only lane 0, for every size and address.
- R6: A write to a bank of width code 1 (16 bits) asserts lanes 1:0 for halfword and word sizes. A byte write asserts lane `addr[0]` in little-endian order and lane `!addr[0]` in big-endian order.
- R7: A byte write to a bank of width code 2 or 3 (32 bits) at offset n asserts lane n in little-endian order (`big_endian` = 0) and lane 3-n in big-endian order.
- R8: A halfword write to a 32-bit bank asserts lanes 1:0 when `addr[1]` XOR `big_endian` is 0, and lanes 3:2 otherwise. A word write asserts all four lanes whatever the address.
- R9: The bank used is `bank_idx`. Its width code is `cfg_width[2*bank_idx +: 2]` and its read-lane-enable bit is `cfg_rden[bank_idx]`.
- R10: `lane_sel` and `err` change only on the clock edge that samples a request. In the cycle after a cycle with `req` = 0, no lane is asserted and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_strap | input | 1 | Lane polarity strap: 0 active low, 1 active high |
| req | input | 1 | Access request valid this cycle |
| wr | input | 1 | 1 write, 0 read |
| size | input | 3 | Transfer size code |
| addr | input | 2 | Low address bits of the transfer |
| big_endian | input | 1 | 1 selects big-endian byte order |
| bank_idx | input | 3 | Bank selected by the access |
| cfg_width | input | 16 | Per-bank width codes, 2 bits per bank |
| cfg_rden | input | 8 | Per-bank read-lane-enable bits |
| lane_sel | output | 4 | Byte lane select pins at strap polarity |
| err | output | 1 | One-cycle error pulse for oversize transfers |

## Verification
The error path and the read path can both claim the same request. This happens with an oversize read to a bank whose read-lane-enable bit is set, where the read rule alone would assert every lane. The bench issues such reads with every illegal size code and expects `err` high with all lanes at the idle level. A second overlap comes from changing the strap while writes are in progress: the lane pattern must keep the polarity captured in reset until a new reset captures the new strap value.

// File: rtl/lane_select_pkg.sv
package lane_select_pkg;

   localparam int WCODE_W = 2;

   typedef enum logic [WCODE_W-1:0] {
      BW_8    = 2'd0,
      BW_16   = 2'd1,
      BW_32   = 2'd2,
      BW_32_R = 2'd3
   } bank_width_e;

   typedef enum logic [2:0] {
      SZ_BYTE = 3'd0,
      SZ_HALF = 3'd1,
      SZ_WORD = 3'd2
   } xfer_size_e;

   localparam int NUM_WIDTHS = 3;

   function automatic logic size_oversize(input logic [2:0] sz);
      return sz > SZ_WORD;
   endfunction

   function automatic int width_slot(input bank_width_e w);
      case (w)
         BW_8:    return 0;
         BW_16:   return 1;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/lsel_bank_cfg.sv
module lsel_bank_cfg
   import lane_select_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [IDX_W-1:0]             bank_idx,
   input  logic [WCODE_W*NUM_BANKS-1:0] cfg_width,
   input  logic [NUM_BANKS-1:0]         cfg_rden,
   output bank_width_e                  width,
   output logic                         rden
);

   logic [WCODE_W-1:0] width_arr [NUM_BANKS];

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_split
      assign width_arr[gb] = cfg_width[gb*WCODE_W +: WCODE_W];
   end

   always_comb begin
      width = BW_8;
      rden  = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (int'(bank_idx) == b) begin
            width = bank_width_e'(width_arr[b]);
            rden  = cfg_rden[b];
         end
      end
   end

endmodule

// File: rtl/lsel_wr_decode.sv
module lsel_wr_decode
   import lane_select_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int BUS_BYTES = 4
) (
   input  logic [2:0]       size,
   input  logic [1:0]       addr,
   input  logic             big_endian,
   output logic [LANES-1:0] mask
);

   int               beat;
   int               offset;
   int               shift;
   logic [LANES:0]   span;

   always_comb begin
      case (size)
         SZ_BYTE: beat = 1;
         SZ_HALF: beat = 2;
         default: beat = 4;
      endcase
      if (beat > BUS_BYTES) beat = BUS_BYTES;
      offset = int'(addr) % BUS_BYTES;
      offset = offset - (offset % beat);
      if (big_endian) shift = BUS_BYTES - beat - offset;
      else            shift = offset;
      span = ({{LANES{1'b0}}, 1'b1} << beat) - 1'b1;
      mask = span[LANES-1:0] << shift;
   end

endmodule

// File: rtl/lsel_out_reg.sv
module lsel_out_reg #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pol_strap,
   input  logic [LANES-1:0] act,
   input  logic             err_d,
   output logic [LANES-1:0] lane_q,
   output logic             err_q
);

   logic pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pol_q <= pol_strap;
   end

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q[gl] <= ~pol_strap;
         else        lane_q[gl] <= pol_q ? act[gl] : ~act[gl];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_d;
   end

endmodule

// File: rtl/lane_select_gen.sv
module lane_select_gen
   import lane_select_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int LANES     = 4,
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pol_strap,
   input  logic                         req,
   input  logic                         wr,
   input  logic [2:0]                   size,
   input  logic [1:0]                   addr,
   input  logic                         big_endian,
   input  logic [IDX_W-1:0]             bank_idx,
   input  logic [WCODE_W*NUM_BANKS-1:0] cfg_width,
   input  logic [NUM_BANKS-1:0]         cfg_rden,
   output logic [LANES-1:0]             lane_sel,
   output logic                         err
);

   if (LANES != 4) begin : g_bad_lanes
      $error("lane_select_gen: LANES must be 4");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("lane_select_gen: NUM_BANKS must be at least 1");
   end

   bank_width_e      bank_w;
   logic             bank_rden;
   logic [LANES-1:0] dec_mask [NUM_WIDTHS];
   logic [LANES-1:0] wr_mask;
   logic [LANES-1:0] act;
   logic             oversize;

   lsel_bank_cfg #(.NUM_BANKS(NUM_BANKS)) u_cfg (
      .bank_idx (bank_idx),
      .cfg_width(cfg_width),
      .cfg_rden (cfg_rden),
      .width    (bank_w),
      .rden     (bank_rden)
   );

   for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_dec
      lsel_wr_decode #(.LANES(LANES), .BUS_BYTES(1 << gw)) u_dec (
         .size      (size),
         .addr      (addr),
         .big_endian(big_endian),
         .mask      (dec_mask[gw])
      );
   end

   assign wr_mask  = dec_mask[width_slot(bank_w)];
   assign oversize = size_oversize(size);

   always_comb begin
      if (!req || oversize) act = '0;
      else if (!wr)         act = {LANES{bank_rden}};
      else                  act = wr_mask;
   end

   lsel_out_reg #(.LANES(LANES)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pol_strap(pol_strap),
      .act      (act),
      .err_d    (req && oversize),
      .lane_q   (lane_sel),
      .err_q    (err)
   );

endmodule

// File: rtl/lane_select_gen_chk.sv
module lane_select_gen_chk #(
   parameter int NUM_BANKS = 8,
   parameter int LANES     = 4,
   localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     pol_strap,
   input logic                     req,
   input logic                     wr,
   input logic [2:0]               size,
   input logic [IDX_W-1:0]         bank_idx,
   input logic [2*NUM_BANKS-1:0]   cfg_width,
   input logic [NUM_BANKS-1:0]     cfg_rden,
   input logic [LANES-1:0]         lane_sel,
   input logic                     err
);

   logic             seen_pol;
   logic [LANES-1:0] on;
   logic [1:0]       wcode;
   logic             legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_pol <= pol_strap;
   end

   assign on    = seen_pol ? lane_sel : ~lane_sel;
   assign wcode = cfg_width[int'(bank_idx)*2 +: 2];
   assign legal = size <= 3'd2;

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (on == '0) && !err);

   p_oversize_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !legal) |=> err && (on == '0));

   p_read_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !wr && legal) |=> (on == (cfg_rden[bank_idx] ? '1 : '0)) && !err);

   p_narrow_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr && legal && wcode == 2'd0) |=> on == 4'b0001);

   p_byte_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr && size == 3'd0) |=> $countones(on) == 1);

   p_write_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr && legal) |=> (on != '0) && !err);

endmodule

bind lane_select_gen lane_select_gen_chk #(.NUM_BANKS(NUM_BANKS), .LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pol_strap(pol_strap),
   .req      (req),
   .wr       (wr),
   .size     (size),
   .bank_idx (bank_idx),
   .cfg_width(cfg_width),
   .cfg_rden (cfg_rden),
   .lane_sel (lane_sel),
   .err      (err)
);

// File: tb/lane_select_gen_test.sv
`timescale 1ns/1ps
module lane_select_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pol_strap = 1'b0;
   logic        req = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  size = 3'd0;
   logic [1:0]  addr = 2'd0;
   logic        big_endian = 1'b0;
   logic [2:0]  bank_idx = 3'd0;
   logic [15:0] cfg_width;
   logic [7:0]  cfg_rden;
   logic [3:0]  lane_sel;
   logic        err;

   int  total = 0;
   int  bad = 0;
   logic cur_pol = 1'b0;
   bit  done = 1'b0;

   // banks: 0=8b 1=16b 2=32b 3=32b(code 3) 4=8b 5=16b 6=32b 7=16b
   assign cfg_width = {2'd1, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0};
   assign cfg_rden  = 8'b0101_0110;

   always #2.5 clk = ~clk;

   lane_select_gen uut (
      .clk(clk), .rst_n(rst_n), .pol_strap(pol_strap), .req(req), .wr(wr),
      .size(size), .addr(addr), .big_endian(big_endian), .bank_idx(bank_idx),
      .cfg_width(cfg_width), .cfg_rden(cfg_rden), .lane_sel(lane_sel), .err(err)
   );

   function automatic logic [3:0] phys(input logic [3:0] a);
      return cur_pol ? a : ~a;
   endfunction

   function automatic logic [3:0] expect_on(input logic w, input logic [2:0] sz,
                                            input logic [1:0] a, input logic be,
                                            input logic [2:0] bk);
      logic [1:0] wc;
      if (sz > 3'd2) return 4'b0000;
      if (!w) return cfg_rden[bk] ? 4'b1111 : 4'b0000;
      wc = cfg_width[bk*2 +: 2];
      if (wc == 2'd0) return 4'b0001;
      if (wc == 2'd1) begin
         if (sz != 3'd0) return 4'b0011;
         return (a[0] ^ be) ? 4'b0010 : 4'b0001;
      end
      case (sz)
         3'd0:    return be ? (4'b1000 >> a) : (4'b0001 << a);
         3'd1:    return (a[1] ^ be) ? 4'b1100 : 4'b0011;
         default: return 4'b1111;
      endcase
   endfunction

   task automatic check(input string rq, input string what,
                        input logic [4:0] act, input logic [4:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: lanes/err actual=%b expected=%b", rq, what, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic [2:0] sz, input logic [1:0] a,
                         input logic be, input logic [2:0] bk,
                         output logic [3:0] ph, output logic e);
      @(negedge clk);
      req = 1'b1; wr = w; size = sz; addr = a; big_endian = be; bank_idx = bk;
      @(negedge clk);
      ph = lane_sel; e = err;
      req = 1'b0;
   endtask

   task automatic do_check(input string rq, input logic w, input logic [2:0] sz,
                           input logic [1:0] a, input logic be, input logic [2:0] bk);
      logic [3:0] ph;
      logic       e;
      access(w, sz, a, be, bk, ph, e);
      check(rq, $sformatf("w=%0b sz=%0d a=%0d be=%0b bk=%0d", w, sz, a, be, bk),
            {ph, e}, {phys(expect_on(w, sz, a, be, bk)), sz > 3'd2});
   endtask

   task automatic apply_reset(input logic strap);
      @(negedge clk);
      pol_strap = strap;
      rst_n = 1'b0;
      #1;
      cur_pol = strap;
      check("R1", "level during reset", {lane_sel, err}, {~{4{strap}}, 1'b0});
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      apply_reset(1'b0);
      @(negedge clk);
      check("R1", "idle after reset", {lane_sel, err}, {4'b1111, 1'b0});
   endtask

   task automatic t_narrow;   // R5
      for (int s = 0; s < 3; s++)
         for (int a = 0; a < 4; a++) begin
            do_check("R5", 1'b1, 3'(s), 2'(a), a[0], 3'd0);
         end
      do_check("R5", 1'b1, 3'd2, 2'd3, 1'b1, 3'd4);
   endtask

   task automatic t_mid;      // R6
      for (int s = 0; s < 3; s++)
         for (int a = 0; a < 4; a++)
            for (int be = 0; be < 2; be++)
               do_check("R6", 1'b1, 3'(s), 2'(a), 1'(be), 3'd1);
   endtask

   task automatic t_wide;     // R7 R8 R9
      for (int a = 0; a < 4; a++)
         for (int be = 0; be < 2; be++) begin
            do_check("R7", 1'b1, 3'd0, 2'(a), 1'(be), 3'd2);
            do_check("R8", 1'b1, 3'd1, 2'(a), 1'(be), 3'd2);
            do_check("R8", 1'b1, 3'd2, 2'(a), 1'(be), 3'd6);
            do_check("R9", 1'b1, 3'd0, 2'(a), 1'(be), 3'd3);
         end
   endtask

   task automatic t_read;     // R4 R9
      for (int bk = 0; bk < 8; bk++)
         for (int s = 0; s < 3; s++)
            do_check("R4", 1'b0, 3'(s), 2'(bk % 4), 1'(s % 2), 3'(bk));
   endtask

   task automatic t_oversize; // R3, overlapping with read-all banks
      for (int s = 3; s < 8; s++) begin
         do_check("R3", 1'b0, 3'(s), 2'd0, 1'b0, 3'd2);
         do_check("R3", 1'b1, 3'(s), 2'd1, 1'b1, 3'd6);
      end
   endtask

   task automatic t_idle;     // R10
      logic [3:0] ph;
      logic       e;
      access(1'b1, 3'd3, 2'd0, 1'b0, 3'd2, ph, e);
      @(negedge clk);
      check("R10", "idle after error", {lane_sel, err}, {phys(4'b0000), 1'b0});
      access(1'b0, 3'd2, 2'd0, 1'b0, 3'd1, ph, e);
      @(negedge clk);
      check("R10", "idle after read", {lane_sel, err}, {phys(4'b0000), 1'b0});
   endtask

   task automatic t_strap;    // R2 R1
      pol_strap = 1'b1;
      do_check("R2", 1'b1, 3'd0, 2'd2, 1'b0, 3'd2);
      @(negedge clk);
      check("R2", "idle keeps reset polarity", {lane_sel, err}, {4'b1111, 1'b0});
      apply_reset(1'b1);
      @(negedge clk);
      check("R1", "idle active-high", {lane_sel, err}, {4'b0000, 1'b0});
      do_check("R1", 1'b1, 3'd1, 2'd2, 1'b0, 3'd2);
      do_check("R1", 1'b0, 3'd2, 2'd0, 1'b0, 3'd1);
      pol_strap = 1'b0;
      do_check("R2", 1'b1, 3'd0, 2'd1, 1'b1, 3'd2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_narrow();
      t_mid();
      t_wide();
      t_read();
      t_oversize();
      t_idle();
      t_strap();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule